// File: doc/BRIEF.md
# Header-Checked Frame Assembler

This block turns a plain stream of bytes into fixed-length frames and passes on only the frames whose header survives an XOR check. Every frame is 13 bytes long. It opens with a 4-byte header and continues with an 8-byte payload. It closes with a single check byte. While the bytes arrive, the block folds the header bytes together with XOR. When the check byte lands, it compares that byte with the folded value.

Two frame stores take turns, so one frame can be collected while the previous one is judged and replayed. A frame that matches is sent out whole, in arrival order, as a burst on consecutive cycles, with flags that mark its first and last byte. A frame that does not match is discarded before any of its bytes reach the output, and a one-cycle error strobe is raised. The input pauses through a ready signal only while both stores hold frames that have not yet been released.

Top module: `hdr_xor_framer`

## Requirements
- R1: During and right after reset, out_valid, out_first, out_last and bad_check are low and in_ready is high.
- R2: A byte is taken on each rising edge where in_valid and in_ready are both high. Every 13 taken bytes form one frame: positions 0 to 3 are the header, positions 4 to 11 are the payload, and position 12 is the check byte.
- R3: A frame passes when its check byte equals the XOR of header positions 0 to 3. The XOR starts from zero for every frame. Payload bytes and the check byte do not enter it.
- R4: A passing frame is emitted as all 13 of its bytes, check byte included, in arrival order, on 13 consecutive cycles with out_valid high.
- R5: out_first is high only with output byte 0 of a frame, and out_last is high only with output byte 12. Both flags are low whenever out_valid is low.
- R6: A failing frame puts no byte on the output. bad_check goes high for exactly one cycle per failing frame and never together with out_valid.
- R7: The first output byte of a passing frame is visible two cycles after the edge that takes its check byte. For a failing frame, bad_check is visible one cycle after that edge.
- R8: in_ready is low only while both frame stores hold frames that have not been released. A byte presented while in_ready is low is not taken and must be held.
- R9: Idle cycles (in_valid low) anywhere inside a frame do not change how it is assembled or checked.
- R10: Collection of the next frame overlaps the judging and emission of the previous one. A continuous input stream is stalled for at most one cycle per frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_data | input | 8 | Incoming byte |
| in_valid | input | 1 | in_data holds a byte |
| in_ready | output | 1 | Block can take a byte this cycle |
| out_data | output | 8 | Forwarded byte |
| out_valid | output | 1 | out_data holds a byte of a passing frame |
| out_first | output | 1 | Marks frame byte 0 |
| out_last | output | 1 | Marks frame byte 12 |
| bad_check | output | 1 | One-cycle strobe for a discarded frame |

## Verification
The edge that takes the check byte sets a store-full flag. The next edge judges the frame: a failing frame raises bad_check right away, while a passing frame starts its replay, and its byte 0 is registered one edge after that. The bench stamps, one half period after the accepting edge, the number of edges elapsed. A monitor on the falling edge stamps the arrival of byte 0 or of the strobe. It then requires distances of exactly two and one. The remaining bytes are expected on the following twelve falling edges with no gap. Stall checks read in_ready on the falling edge, when only registered state drives it.

// File: rtl/hdr_xor_framer.sv
module hdr_xor_framer #(
  parameter int HDR_BYTES = 4,
  parameter int PAY_BYTES = 8,
  parameter int BW        = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [BW-1:0] in_data,
  input  logic          in_valid,
  output logic          in_ready,
  output logic [BW-1:0] out_data,
  output logic          out_valid,
  output logic          out_first,
  output logic          out_last,
  output logic          bad_check
);
  localparam int FRAME = HDR_BYTES + PAY_BYTES + 1;
  localparam int IW = $clog2(FRAME);
  localparam logic [IW-1:0] LAST = IW'(FRAME - 1);
  localparam logic [IW-1:0] HEND = IW'(HDR_BYTES);

  logic [BW-1:0] store [2][FRAME];
  logic [1:0]    full, pass;
  logic          wr_sel, rd_sel, streaming;
  logic [IW-1:0] wr_idx, rd_idx;
  logic [BW-1:0] fold;

  wire take     = in_valid && in_ready;
  wire wr_done  = take && (wr_idx == LAST);
  wire judge    = full[rd_sel] && !streaming;
  wire rd_free  = (judge && !pass[rd_sel]) || (streaming && rd_idx == LAST);

  assign in_ready = !full[wr_sel];

  always_ff @(posedge clk)
    if (take) store[wr_sel][wr_idx] <= in_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_sel <= 1'b0;
      wr_idx <= '0;
      fold   <= '0;
      pass   <= '0;
    end else if (take) begin
      if (wr_done) begin
        wr_idx       <= '0;
        wr_sel       <= ~wr_sel;
        fold         <= '0;
        pass[wr_sel] <= (fold == in_data);
      end else begin
        wr_idx <= wr_idx + 1'b1;
        if (wr_idx < HEND) fold <= fold ^ in_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) full <= '0;
    else begin
      if (wr_done) full[wr_sel] <= 1'b1;
      if (rd_free) full[rd_sel] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_sel    <= 1'b0;
      rd_idx    <= '0;
      streaming <= 1'b0;
      out_data  <= '0;
      out_valid <= 1'b0;
      out_first <= 1'b0;
      out_last  <= 1'b0;
      bad_check <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      out_first <= 1'b0;
      out_last  <= 1'b0;
      bad_check <= 1'b0;
      if (judge) begin
        if (pass[rd_sel]) begin
          streaming <= 1'b1;
          rd_idx    <= '0;
        end else begin
          bad_check <= 1'b1;
          rd_sel    <= ~rd_sel;
        end
      end else if (streaming) begin
        out_valid <= 1'b1;
        out_data  <= store[rd_sel][rd_idx];
        out_first <= (rd_idx == '0);
        out_last  <= (rd_idx == LAST);
        if (rd_idx == LAST) begin
          streaming <= 1'b0;
          rd_sel    <= ~rd_sel;
        end else begin
          rd_idx <= rd_idx + 1'b1;
        end
      end
    end
  end
endmodule

module hdr_xor_framer_chk (
  input logic clk,
  input logic rst_n,
  input logic out_valid,
  input logic out_first,
  input logic out_last,
  input logic bad_check
);
  assert_first_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_first |-> out_valid);
  assert_last_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);
  assert_burst_gapless_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_last) |=> out_valid);
  assert_strobe_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bad_check |-> !out_valid);
  assert_strobe_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bad_check |=> !bad_check);
endmodule

bind hdr_xor_framer hdr_xor_framer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .out_valid(out_valid),
  .out_first(out_first), .out_last(out_last), .bad_check(bad_check));

// File: tb/hdr_xor_framer_bench.sv
`timescale 1ns/1ps
module hdr_xor_framer_bench;
  typedef logic [7:0] frame_t [13];

  logic clk = 0, rst_n = 0;
  logic [7:0] in_data = '0;
  logic in_valid = 0;
  logic in_ready, out_valid, out_first, out_last, bad_check;
  logic [7:0] out_data;

  hdr_xor_framer u_hdr_xor_framer (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
    .in_ready(in_ready), .out_data(out_data), .out_valid(out_valid),
    .out_first(out_first), .out_last(out_last), .bad_check(bad_check));

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0;
  int cyc = 0, stalls = 0;
  int exp_n = 0, got_n = 0, bad_n = 0;
  int t_last = 0, t_first = 0, t_bad = 0;
  logic [7:0] exp_q [512];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (out_valid) begin
      if (got_n >= exp_n) chk(0, "R6 byte from a frame that should be dropped", got_n, exp_n);
      else chk(out_data == exp_q[got_n], "R4 output byte", out_data, exp_q[got_n]);
      chk(out_first == (got_n % 13 == 0), "R5 out_first", out_first, got_n % 13 == 0);
      chk(out_last == (got_n % 13 == 12), "R5 out_last", out_last, got_n % 13 == 12);
      if (got_n % 13 == 0) t_first = cyc;
      got_n++;
    end else begin
      if (out_first || out_last) chk(0, "R5 flag without valid", 1, 0);
    end
    if (bad_check) begin
      bad_n++;
      t_bad = cyc;
    end
  end

  function automatic frame_t mk(input int seed, input bit good);
    frame_t f;
    logic [7:0] x = '0;
    for (int i = 0; i < 12; i++) f[i] = 8'((seed * 37 + i * 11 + 5) ^ (i << 4));
    for (int i = 0; i < 4; i++) x ^= f[i];
    f[12] = good ? x : (x ^ 8'h5A);
    return f;
  endfunction

  task automatic expect_frame(input frame_t f);
    for (int i = 0; i < 13; i++) exp_q[exp_n + i] = f[i];
    exp_n += 13;
  endtask

  task automatic send(input frame_t f, input int gap);
    for (int i = 0; i < 13; i++) begin
      in_valid = 1;
      in_data  = f[i];
      while (!in_ready) begin stalls++; @(negedge clk); end
      @(negedge clk);
      if (i == 12) t_last = cyc;
      if (gap > 0) begin
        in_valid = 0;
        repeat (gap) @(negedge clk);
      end
    end
  endtask

  task automatic idle(input int n);
    in_valid = 0;
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    chk(in_ready == 1, "R1 in_ready after reset", in_ready, 1);
    chk(out_valid == 0, "R1 out_valid after reset", out_valid, 0);
    chk(bad_check == 0, "R1 bad_check after reset", bad_check, 0);
    chk({out_first, out_last} == 2'b00, "R1 flags after reset", {out_first, out_last}, 0);
  endtask

  task automatic t_single_good;
    frame_t f = mk(1, 1);
    expect_frame(f);
    send(f, 0);
    idle(20);
    chk(got_n == exp_n, "R2 R4 bytes of a passing frame", got_n, exp_n);
    chk(t_first - t_last == 2, "R7 first byte latency", t_first - t_last, 2);
  endtask

  task automatic t_single_bad;
    int b0 = bad_n, g0 = got_n;
    send(mk(2, 0), 0);
    idle(20);
    chk(bad_n == b0 + 1, "R6 one strobe per failing frame", bad_n, b0 + 1);
    chk(got_n == g0, "R6 failing frame not forwarded", got_n, g0);
    chk(t_bad - t_last == 1, "R7 strobe latency", t_bad - t_last, 1);
  endtask

  task automatic t_header_only_r3;
    frame_t f = mk(3, 1);
    frame_t z;
    int b0 = bad_n;
    logic [7:0] px = '0;
    for (int i = 4; i < 12; i++) px ^= f[i];
    f[12] = f[12] ^ px;
    send(f, 0);
    idle(20);
    chk(bad_n == b0 + 1, "R3 payload must not enter the XOR", bad_n, b0 + 1);
    z = mk(4, 1);
    z[0] = 8'h3C; z[1] = 8'h3C; z[2] = 8'hA5; z[3] = 8'hA5; z[12] = 8'h00;
    expect_frame(z);
    send(z, 0);
    idle(20);
    chk(got_n == exp_n, "R3 XOR restarts at zero per frame", got_n, exp_n);
    chk(bad_n == b0 + 1, "R3 zero-check frame passes", bad_n, b0 + 1);
  endtask

  task automatic t_gaps_r9;
    frame_t f = mk(5, 1);
    int b0 = bad_n;
    expect_frame(f);
    send(f, 3);
    idle(20);
    chk(got_n == exp_n, "R9 frame with idle gaps", got_n, exp_n);
    chk(bad_n == b0, "R9 no false strobe", bad_n, b0);
  endtask

  task automatic t_burst_r10;
    int s0 = stalls, b0 = bad_n;
    frame_t f;
    for (int k = 0; k < 5; k++) begin
      f = mk(10 + k, k != 2);
      if (k != 2) expect_frame(f);
      send(f, 0);
    end
    idle(60);
    chk(got_n == exp_n, "R10 back-to-back passing frames", got_n, exp_n);
    chk(bad_n == b0 + 1, "R6 strobe inside a burst", bad_n, b0 + 1);
    chk(stalls > s0, "R8 in_ready drops when both stores are full", stalls - s0, 1);
    chk(stalls - s0 <= 4, "R10 overlap keeps stalls short", stalls - s0, 4);
  endtask

  initial begin
    #(200000 * 5);
    chk(0, "watchdog expired", cyc, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_single_good;
    t_single_bad;
    t_header_only_r3;
    t_gaps_r9;
    t_burst_r10;
    chk(got_n == exp_n, "R4 total forwarded bytes", got_n, exp_n);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule